// File: doc/BRIEF.md
# Shared-Buffer Doorbell Interrupt Unit

Two processors, an application processor (AP) and a modem, share a 16 KB buffer. This unit lets either side signal the other by writing into that buffer. It watches the write traffic from both sides. When one side writes to the location chosen as the other side's doorbell, the unit latches a pending interrupt toward the other side and holds it on a level output.

The AP programs both doorbell locations through a small register port. Each direction is cleared in its own way:
- The AP removes its own interrupt by writing to a dedicated clear register.
- The modem removes its interrupt by writing a 1 into its doorbell location.

The two default doorbell locations share one 32-bit word. For that reason, a doorbell fires only when the write's byte strobes cover the half-word that the doorbell names.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset, `irq_to_ap` and `irq_to_md` are low. Register index 0 (AP-bound doorbell) reads 0x3FFE, and register index 1 (modem-bound doorbell) reads 0x3FFC.
- R2: The doorbell registers keep only 14 bits. A register read returns the value zero-extended to 32 bits. Register index 2 (clear) is write-only and reads 0.
- R3: A modem write sets `irq_to_ap` one clock later when all of the following hold:
  - its address bits [13:2] equal the AP-bound doorbell's bits [13:2];
  - it has at least one strobe set in the half-word that doorbell bit 1 selects (strobes [1:0] for half 0, strobes [3:2] for half 1).
- R4: A write to the doorbell's word whose strobes lie only in the other half-word raises no interrupt, in either direction.
- R5: `irq_to_ap` stays high until an AP register write to index 2. Any data value clears it, and other traffic leaves it unchanged.
- R6: An AP buffer write matching the modem-bound doorbell, under the same word and half-word rule as R3, sets `irq_to_md` one clock later.
- R7: A modem write clears `irq_to_md` one clock later when all of the following hold:
  - it hits the modem-bound doorbell's word;
  - the strobe of the low byte of that half-word is set;
  - data bit 0 of that half-word (bit 0 for half 0, bit 16 for half 1) is 1.

  With that bit at 0, the interrupt stays pending.
- R8: When a set and a clear for the same interrupt fall in one cycle, the interrupt is high afterwards.
- R9: A new doorbell address written to index 0 or 1 applies from the next cycle. The old location no longer triggers.
- R10: A write only raises the interrupt toward the opposite side. A write to a non-matching address raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ap_reg_valid | input | 1 | AP register access strobe |
| ap_reg_write | input | 1 | 1 = register write, 0 = read |
| ap_reg_idx | input | 2 | Register index: 0 AP-bound doorbell, 1 modem-bound doorbell, 2 clear |
| ap_reg_wdata | input | 32 | Register write data |
| ap_reg_rdata | output | 32 | Register read data (combinational) |
| ap_mem_valid | input | 1 | AP buffer write strobe |
| ap_mem_addr | input | 14 | AP buffer byte address |
| ap_mem_be | input | 4 | AP buffer byte strobes |
| md_mem_valid | input | 1 | Modem buffer write strobe |
| md_mem_addr | input | 14 | Modem buffer byte address |
| md_mem_be | input | 4 | Modem buffer byte strobes |
| md_mem_wdata | input | 32 | Modem buffer write data |
| irq_to_ap | output | 1 | Level interrupt toward the AP |
| irq_to_md | output | 1 | Level interrupt toward the modem |

## Verification
The assertions check the internal set and clear events against the interrupt outputs on every cycle:
- a set event raises its output;
- a lone clear drops it;
- a pending interrupt holds while no clear occurs;
- nothing rises without a set event;
- read data never shows bits above the 14-bit field.

Whether those events come from the right addresses, half-words, strobes and data bits can only be shown by the bench's scenarios, which compare against independently computed expectations. The same applies to reprogramming the doorbells and to the shared-word case.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_AW = 14;
  localparam int unsigned MBX_DW = 32;

  typedef enum logic [1:0] {
    REG_AP_DB  = 2'd0,
    REG_MD_DB  = 2'd1,
    REG_AP_CLR = 2'd2,
    REG_RSVD   = 2'd3
  } mbx_reg_e;
endpackage

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
#(
  parameter int unsigned AW = MBX_AW,
  parameter int unsigned DW = MBX_DW,
  parameter logic [AW-1:0] AP_RST = 14'h3FFE,
  parameter logic [AW-1:0] MD_RST = 14'h3FFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          write,
  input  logic [1:0]    idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] ap_db,
  output logic [AW-1:0] md_db,
  output logic          ap_clr
);
  logic wr_en;
  logic rd_en;

  function automatic logic [DW-1:0] widen(input logic [AW-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[AW-1:0] = v;
    return r;
  endfunction

  assign wr_en  = valid && write;
  assign rd_en  = valid && !write;
  assign ap_clr = wr_en && (mbx_reg_e'(idx) == REG_AP_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_db <= AP_RST;
      md_db <= MD_RST;
    end else if (wr_en) begin
      if (mbx_reg_e'(idx) == REG_AP_DB) ap_db <= wdata[AW-1:0];
      if (mbx_reg_e'(idx) == REG_MD_DB) md_db <= wdata[AW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (mbx_reg_e'(idx))
        REG_AP_DB: rdata = widen(ap_db);
        REG_MD_DB: rdata = widen(md_db);
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbx_db_match.sv
module mbx_db_match
  import mbx_pkg::*;
#(
  parameter int unsigned AW       = MBX_AW,
  parameter int unsigned DW       = MBX_DW,
  parameter bit          CLR_MODE = 1'b0
) (
  input  logic            valid,
  input  logic [AW-1:0]   addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  input  logic [AW-1:0]   db,
  output logic            fire
);
  localparam int unsigned BEW = DW / 8;
  localparam int unsigned LB  = $clog2(BEW);

  function automatic logic same_word(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:LB] == b[AW-1:LB];
  endfunction

  function automatic int unsigned half_of(input logic [AW-1:0] a);
    return int'(a[LB-1:0]) >> 1;
  endfunction

  function automatic logic half_strobed(input logic [BEW-1:0] s, input int unsigned h);
    return |s[2*h +: 2];
  endfunction

  logic word_hit;
  logic half_hit;
  assign word_hit = valid && same_word(addr, db);
  assign half_hit = word_hit && half_strobed(be, half_of(db));

  generate
    if (CLR_MODE) begin : g_clear
      assign fire = word_hit && be[2*half_of(db)] && wdata[16*half_of(db)];
    end else begin : g_set
      assign fire = half_hit;
    end
  endgenerate
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end
endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
  import mbx_pkg::*;
#(
  parameter int unsigned AW = MBX_AW,
  parameter int unsigned DW = MBX_DW,
  parameter logic [AW-1:0] AP_DB_RST = 14'h3FFE,
  parameter logic [AW-1:0] MD_DB_RST = 14'h3FFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ap_reg_valid,
  input  logic            ap_reg_write,
  input  logic [1:0]      ap_reg_idx,
  input  logic [DW-1:0]   ap_reg_wdata,
  output logic [DW-1:0]   ap_reg_rdata,
  input  logic            ap_mem_valid,
  input  logic [AW-1:0]   ap_mem_addr,
  input  logic [DW/8-1:0] ap_mem_be,
  input  logic            md_mem_valid,
  input  logic [AW-1:0]   md_mem_addr,
  input  logic [DW/8-1:0] md_mem_be,
  input  logic [DW-1:0]   md_mem_wdata,
  output logic            irq_to_ap,
  output logic            irq_to_md
);
  logic [AW-1:0] ap_db;
  logic [AW-1:0] md_db;
  logic          ap_set;
  logic          ap_clr;
  logic          md_set;
  logic          md_clr;

  mbx_regfile #(.AW(AW), .DW(DW), .AP_RST(AP_DB_RST), .MD_RST(MD_DB_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .valid(ap_reg_valid), .write(ap_reg_write),
    .idx(ap_reg_idx), .wdata(ap_reg_wdata), .rdata(ap_reg_rdata),
    .ap_db(ap_db), .md_db(md_db), .ap_clr(ap_clr)
  );

  mbx_db_match #(.AW(AW), .DW(DW), .CLR_MODE(1'b0)) u_ap_hit (
    .valid(md_mem_valid), .addr(md_mem_addr), .be(md_mem_be),
    .wdata(md_mem_wdata), .db(ap_db), .fire(ap_set)
  );

  mbx_db_match #(.AW(AW), .DW(DW), .CLR_MODE(1'b0)) u_md_hit (
    .valid(ap_mem_valid), .addr(ap_mem_addr), .be(ap_mem_be),
    .wdata('0), .db(md_db), .fire(md_set)
  );

  mbx_db_match #(.AW(AW), .DW(DW), .CLR_MODE(1'b1)) u_md_ack (
    .valid(md_mem_valid), .addr(md_mem_addr), .be(md_mem_be),
    .wdata(md_mem_wdata), .db(md_db), .fire(md_clr)
  );

  mbx_irq_flag u_flag_ap (.clk(clk), .rst_n(rst_n), .set(ap_set), .clr(ap_clr), .irq(irq_to_ap));
  mbx_irq_flag u_flag_md (.clk(clk), .rst_n(rst_n), .set(md_set), .clr(md_clr), .irq(irq_to_md));
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
  parameter int unsigned AW = 14,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ap_set,
  input logic          ap_clr,
  input logic          md_set,
  input logic          md_clr,
  input logic          irq_to_ap,
  input logic          irq_to_md,
  input logic [DW-1:0] ap_reg_rdata
);
  p_ap_set_r3: assert property (@(posedge clk) disable iff (!rst_n) ap_set |=> irq_to_ap);
  p_md_set_r6: assert property (@(posedge clk) disable iff (!rst_n) md_set |=> irq_to_md);
  p_ap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n) irq_to_ap && !ap_clr |=> irq_to_ap);
  p_ap_clear_r5: assert property (@(posedge clk) disable iff (!rst_n) ap_clr && !ap_set |=> !irq_to_ap);
  p_md_clear_r7: assert property (@(posedge clk) disable iff (!rst_n) md_clr && !md_set |=> !irq_to_md);
  p_md_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) irq_to_md && !md_clr |=> irq_to_md);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n) (ap_set && ap_clr) || (md_set && md_clr) |=> (irq_to_ap || irq_to_md));
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n) !irq_to_ap && !ap_set |=> !irq_to_ap);
  p_rdata_width_r2: assert property (@(posedge clk) disable iff (!rst_n) ap_reg_rdata[DW-1:AW] == '0);
endmodule

bind mbx_doorbell_top mbx_doorbell_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ap_set(ap_set), .ap_clr(ap_clr),
  .md_set(md_set), .md_clr(md_clr), .irq_to_ap(irq_to_ap),
  .irq_to_md(irq_to_md), .ap_reg_rdata(ap_reg_rdata)
);

// File: tb/tb_mbx_doorbell_top.sv
`timescale 1ns/1ps
module tb_mbx_doorbell_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ap_reg_valid = 1'b0, ap_reg_write = 1'b0;
  logic [1:0]  ap_reg_idx = '0;
  logic [31:0] ap_reg_wdata = '0;
  logic [31:0] ap_reg_rdata;
  logic        ap_mem_valid = 1'b0;
  logic [13:0] ap_mem_addr = '0;
  logic [3:0]  ap_mem_be = '0;
  logic        md_mem_valid = 1'b0;
  logic [13:0] md_mem_addr = '0;
  logic [3:0]  md_mem_be = '0;
  logic [31:0] md_mem_wdata = '0;
  logic        irq_to_ap, irq_to_md;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbx_doorbell_top dut (
    .clk(clk), .rst_n(rst_n), .ap_reg_valid(ap_reg_valid), .ap_reg_write(ap_reg_write),
    .ap_reg_idx(ap_reg_idx), .ap_reg_wdata(ap_reg_wdata), .ap_reg_rdata(ap_reg_rdata),
    .ap_mem_valid(ap_mem_valid), .ap_mem_addr(ap_mem_addr), .ap_mem_be(ap_mem_be),
    .md_mem_valid(md_mem_valid), .md_mem_addr(md_mem_addr), .md_mem_be(md_mem_be),
    .md_mem_wdata(md_mem_wdata), .irq_to_ap(irq_to_ap), .irq_to_md(irq_to_md)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    ap_reg_valid = 1; ap_reg_write = 1; ap_reg_idx = idx; ap_reg_wdata = d;
    @(negedge clk);
    ap_reg_valid = 0; ap_reg_write = 0;
  endtask

  task automatic reg_read(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    ap_reg_valid = 1; ap_reg_write = 0; ap_reg_idx = idx;
    #1 d = ap_reg_rdata;
    ap_reg_valid = 0;
  endtask

  task automatic ap_wr(input logic [13:0] a, input logic [3:0] be);
    @(negedge clk);
    ap_mem_valid = 1; ap_mem_addr = a; ap_mem_be = be;
    @(negedge clk);
    ap_mem_valid = 0;
  endtask

  task automatic md_wr(input logic [13:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    md_mem_valid = 1; md_mem_addr = a; md_mem_be = be; md_mem_wdata = d;
    @(negedge clk);
    md_mem_valid = 0;
  endtask

  task automatic t_reset_r1();
    logic [31:0] v;
    check("R1 irq_to_ap", {31'd0, irq_to_ap}, 0);
    check("R1 irq_to_md", {31'd0, irq_to_md}, 0);
    reg_read(2'd0, v); check("R1 ap doorbell", v, 32'h3FFE);
    reg_read(2'd1, v); check("R1 md doorbell", v, 32'h3FFC);
  endtask

  task automatic t_width_r2();
    logic [31:0] v;
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, v); check("R2 zero-extend", v, 32'h3FFF);
    reg_read(2'd2, v); check("R2 clear reads 0", v, 0);
    reg_write(2'd0, 32'h3FFE);
  endtask

  task automatic t_ap_set_clear_r3_r5();
    md_wr(14'h3FFE, 4'b1100, 0);
    check("R3 modem hit sets irq_to_ap", {31'd0, irq_to_ap}, 1);
    md_wr(14'h0040, 4'b1111, 32'hFFFF_FFFF);
    ap_wr(14'h0040, 4'b1111);
    check("R5 holds under other traffic", {31'd0, irq_to_ap}, 1);
    reg_write(2'd2, 32'h0);
    check("R5 clear register drops irq", {31'd0, irq_to_ap}, 0);
  endtask

  task automatic t_half_r4();
    md_wr(14'h3FFC, 4'b0011, 0);
    check("R4 wrong half no irq_to_ap", {31'd0, irq_to_ap}, 0);
    ap_wr(14'h3FFC, 4'b1100);
    check("R4 wrong half no irq_to_md", {31'd0, irq_to_md}, 0);
    md_wr(14'h3FFE, 4'b0100, 0);
    check("R4 one strobe in half sets", {31'd0, irq_to_ap}, 1);
    reg_write(2'd2, 32'h1);
  endtask

  task automatic t_md_set_clear_r6_r7();
    ap_wr(14'h3FFC, 4'b0001);
    check("R6 ap hit sets irq_to_md", {31'd0, irq_to_md}, 1);
    md_wr(14'h3FFC, 4'b0011, 32'h0);
    check("R7 write of 0 keeps pending", {31'd0, irq_to_md}, 1);
    md_wr(14'h3FFC, 4'b1100, 32'hFFFF_FFFF);
    check("R7 other half keeps pending", {31'd0, irq_to_md}, 1);
    md_wr(14'h3FFC, 4'b0001, 32'h1);
    check("R7 write of 1 clears", {31'd0, irq_to_md}, 0);
  endtask

  task automatic t_set_wins_r8();
    @(negedge clk);
    md_mem_valid = 1; md_mem_addr = 14'h3FFE; md_mem_be = 4'b1100; md_mem_wdata = 0;
    ap_reg_valid = 1; ap_reg_write = 1; ap_reg_idx = 2'd2;
    @(negedge clk);
    md_mem_valid = 0; ap_reg_valid = 0; ap_reg_write = 0;
    check("R8 ap set beats clear", {31'd0, irq_to_ap}, 1);
    reg_write(2'd2, 0);
    @(negedge clk);
    ap_mem_valid = 1; ap_mem_addr = 14'h3FFC; ap_mem_be = 4'b0011;
    md_mem_valid = 1; md_mem_addr = 14'h3FFC; md_mem_be = 4'b0011; md_mem_wdata = 1;
    @(negedge clk);
    ap_mem_valid = 0; md_mem_valid = 0;
    check("R8 md set beats clear", {31'd0, irq_to_md}, 1);
    md_wr(14'h3FFC, 4'b0011, 1);
    check("R8 md cleared after", {31'd0, irq_to_md}, 0);
  endtask

  task automatic t_shared_word_r7_r3();
    ap_wr(14'h3FFC, 4'b0011);
    md_wr(14'h3FFC, 4'b1111, 32'h0000_0001);
    check("R3 full-word modem write rings AP", {31'd0, irq_to_ap}, 1);
    check("R7 same write clears modem irq", {31'd0, irq_to_md}, 0);
    reg_write(2'd2, 0);
  endtask

  task automatic t_reprogram_r9();
    logic [31:0] v;
    reg_write(2'd0, 32'h0102);
    reg_write(2'd1, 32'h0200);
    reg_read(2'd1, v); check("R9 md doorbell readback", v, 32'h0200);
    md_wr(14'h3FFE, 4'b1100, 0);
    check("R9 old ap location silent", {31'd0, irq_to_ap}, 0);
    md_wr(14'h0100, 4'b1100, 0);
    check("R9 new ap location rings", {31'd0, irq_to_ap}, 1);
    reg_write(2'd2, 0);
    ap_wr(14'h3FFC, 4'b0011);
    check("R9 old md location silent", {31'd0, irq_to_md}, 0);
    ap_wr(14'h0200, 4'b0011);
    check("R9 new md location rings", {31'd0, irq_to_md}, 1);
    md_wr(14'h0200, 4'b0001, 1);
    reg_write(2'd0, 32'h3FFE);
    reg_write(2'd1, 32'h3FFC);
  endtask

  task automatic t_direction_r10();
    ap_wr(14'h3FFE, 4'b1100);
    check("R10 AP write to AP doorbell", {31'd0, irq_to_ap}, 0);
    md_wr(14'h3FFC, 4'b0011, 0);
    check("R10 modem write to modem doorbell", {31'd0, irq_to_md}, 0);
    md_wr(14'h1FFE, 4'b1100, 0);
    check("R10 non-matching address", {31'd0, irq_to_ap}, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_width_r2();
    t_ap_set_clear_r3_r5();
    t_half_r4();
    t_md_set_clear_r6_r7();
    t_set_wins_r8();
    t_shared_word_r7_r3();
    t_reprogram_r9();
    t_direction_r10();
    done = 1'b1;
    report();
  end
endmodule